// File: doc/BRIEF.md
# Clock request pair gate

This block stops and restarts a set of differential clock output pairs under the control of several active-low clock request inputs. The request inputs may change at any time, with no relation to any clock. Each one is passed through a two-stage synchronizer. A change is accepted only after the synchronized level has been seen unchanged on two consecutive rising edges of the reference clock.

A grouping map decides which pairs each request controls. It holds one byte per request in the default build, and a pair may belong to several groups. When an accepted request becomes active, each pair in its group stops at its next transition into the parked level. The drive-mode input selects what a stopped pair does:
- In mode 0, the true leg is driven high and the complement leg low.
- In mode 1, both legs are released (output enables low) and read as low.

When requests are released, every pair that is freed by the same accepted release restarts on the same edge. This happens a fixed number of cycles later.

A running pair toggles on every reference clock edge. This models a divided output clock that the block gates.

Top module: `dif_req_gate`

## Requirements
- R1: During reset and after it, every pair runs. The output enables are high, and the complement leg is always the inverse of the true leg. After the n-th rising edge that follows reset release, the true leg equals 1 when n is odd and 0 when n is even.
- R2: A request input change is accepted on the 4th rising edge after the change; a change lasting a single clock period is rejected, and the outputs keep running.
- R3: Bit r*NOUT+j of `grp_map` set to 1 places pair j in the group of request r. A pair with no set bit for any active request keeps running.
- R4: An accepted assertion (input low) freezes each selected pair at the first rising edge, no earlier than the 5th after the input change, at which its true leg would take the parked level. The parked level is 1 in mode 0 and 0 in mode 1.
- R5: With `drive_mode` = 0, a stopped pair has true = 1, complement = 0, and both enables high.
- R6: With `drive_mode` = 1, a stopped pair has both enables low and both legs at 0. Both enables of a pair are always equal.
- R7: After an accepted release (input high), a freed pair runs again exactly RESUME_LAT rising edges after acceptance. This is the 6th edge after the input change by default. From that edge it follows the R1 toggle pattern.
- R8: All pairs freed by the same accepted release resume on the same edge.
- R9: A pair in several groups stops when any of its requests is active. It resumes only after all of them are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference differential clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low reset |
| req_n | input | NREQ | Asynchronous active-low clock requests |
| grp_map | input | NREQ*NOUT | Group membership, one NOUT-bit field per request |
| drive_mode | input | 1 | Stopped state select: 0 parks driven, 1 releases both legs |
| dif_t | output | NOUT | True leg of each output pair |
| dif_c | output | NOUT | Complement leg of each output pair |
| oe_t | output | NOUT | Output enable of each true leg |
| oe_c | output | NOUT | Output enable of each complement leg |

## Verification
Some properties are checked by assertions on every cycle:
- An accepted request level was present at the input on the sampled edges before it.
- A pair only starts a stop when one of its requests is active, and only just after a transition into its parked level.
- A pair only resumes after its requests have been inactive for at least two cycles.
- The enables always move together, and released legs are low.
- Mode 0 never releases a leg.

Other properties can only be shown by the bench scenarios. These are the exact stop and resume edges for both parities and both modes, the rejection of a one-cycle request pulse, partial release of overlapping groups, and the same-edge restart of pairs freed together.

// File: rtl/dif_req_pkg.sv
package dif_req_pkg;

   typedef enum logic {
      PARK_DRIVEN = 1'b0,
      PARK_FLOAT  = 1'b1
   } park_mode_e;

   // Level the true leg holds when a pair freezes in the given mode
   function automatic logic park_level(input logic mode);
      return (mode == PARK_DRIVEN) ? 1'b1 : 1'b0;
   endfunction

   localparam int unsigned MIN_RESUME = 2;
   localparam int unsigned MAX_RESUME = 6;

endpackage

// File: rtl/dif_req_sync_deb.sv
module dif_req_sync_deb #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_n_raw,
   output logic req_act
);

   logic [SYNC_STAGES-1:0] chain;
   logic                   last_q;
   logic                   synced;

   assign synced = chain[SYNC_STAGES-1];

   // Synchronizer chain, idle level is high (no request)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], req_n_raw};
      end
   end

   // Accept a level only when it matched on two consecutive edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= 1'b1;
         req_act <= 1'b0;
      end else begin
         last_q <= synced;
         if (synced == last_q) begin
            req_act <= ~synced;
         end
      end
   end

endmodule

// File: rtl/dif_req_group.sv
module dif_req_group #(
   parameter int unsigned NREQ = 2,
   parameter int unsigned NOUT = 8
) (
   input  logic [NREQ-1:0]      req_act,
   input  logic [NREQ*NOUT-1:0] grp_map,
   output logic [NOUT-1:0]      want_stop
);

   always_comb begin
      want_stop = '0;
      for (int j = 0; j < NOUT; j++) begin
         for (int r = 0; r < NREQ; r++) begin
            if (req_act[r] && grp_map[r*NOUT + j]) begin
               want_stop[j] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dif_pair_gate.sv
module dif_pair_gate
   import dif_req_pkg::*;
#(
   parameter int unsigned RESUME_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic ph_next,
   input  logic drive_mode,
   output logic stop_q,
   output logic t_q,
   output logic c_q,
   output logic oe_q
);

   localparam int unsigned HOLD_DEPTH = RESUME_LAT - 1;

   logic [HOLD_DEPTH-1:0] hist;
   logic                  hold;
   logic                  stop_n;
   logic                  lvl;

   generate
      if (HOLD_DEPTH == 1) begin : g_hist_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist <= '0;
            else        hist <= want;
         end
      end else begin : g_hist_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist <= '0;
            else        hist <= {hist[HOLD_DEPTH-2:0], want};
         end
      end
   endgenerate

   always_comb begin
      lvl  = park_level(drive_mode);
      hold = want | (|hist);
      if (stop_q) begin
         stop_n = hold;
      end else begin
         stop_n = want & (ph_next == lvl);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q <= 1'b0;
         t_q    <= 1'b0;
         c_q    <= 1'b1;
         oe_q   <= 1'b1;
      end else begin
         stop_q <= stop_n;
         if (stop_n) begin
            if (drive_mode == PARK_FLOAT) begin
               t_q  <= 1'b0;
               c_q  <= 1'b0;
               oe_q <= 1'b0;
            end else begin
               t_q  <= 1'b1;
               c_q  <= 1'b0;
               oe_q <= 1'b1;
            end
         end else begin
            t_q  <= ph_next;
            c_q  <= ~ph_next;
            oe_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dif_req_gate.sv
module dif_req_gate
   import dif_req_pkg::*;
#(
   parameter int unsigned NREQ        = 2,
   parameter int unsigned NOUT        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RESUME_LAT  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NREQ-1:0]      req_n,
   input  logic [NREQ*NOUT-1:0] grp_map,
   input  logic                 drive_mode,
   output logic [NOUT-1:0]      dif_t,
   output logic [NOUT-1:0]      dif_c,
   output logic [NOUT-1:0]      oe_t,
   output logic [NOUT-1:0]      oe_c
);

   generate
      if (NREQ < 1) begin : g_bad_nreq
         $error("dif_req_gate: NREQ must be at least 1");
      end
      if (NOUT < 1) begin : g_bad_nout
         $error("dif_req_gate: NOUT must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dif_req_gate: SYNC_STAGES must be at least 2");
      end
      if (RESUME_LAT < MIN_RESUME || RESUME_LAT > MAX_RESUME) begin : g_bad_lat
         $error("dif_req_gate: RESUME_LAT out of range 2..6");
      end
   endgenerate

   logic [NREQ-1:0] req_act;
   logic [NOUT-1:0] want_stop;
   logic [NOUT-1:0] stop_q;
   logic [NOUT-1:0] oe_q;
   logic            ph;
   logic            ph_next;

   assign ph_next = ~ph;

   // Shared phase of the running output clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= 1'b0;
      else        ph <= ph_next;
   end

   genvar gr;
   generate
      for (gr = 0; gr < NREQ; gr++) begin : g_req
         dif_req_sync_deb #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_deb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_n_raw (req_n[gr]),
            .req_act   (req_act[gr])
         );
      end
   endgenerate

   dif_req_group #(
      .NREQ (NREQ),
      .NOUT (NOUT)
   ) u_group (
      .req_act   (req_act),
      .grp_map   (grp_map),
      .want_stop (want_stop)
   );

   genvar gj;
   generate
      for (gj = 0; gj < NOUT; gj++) begin : g_pair
         dif_pair_gate #(
            .RESUME_LAT (RESUME_LAT)
         ) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .want       (want_stop[gj]),
            .ph_next    (ph_next),
            .drive_mode (drive_mode),
            .stop_q     (stop_q[gj]),
            .t_q        (dif_t[gj]),
            .c_q        (dif_c[gj]),
            .oe_q       (oe_q[gj])
         );
      end
   endgenerate

   assign oe_t = oe_q;
   assign oe_c = oe_q;

endmodule

// File: rtl/dif_req_gate_chk.sv
module dif_req_gate_chk #(
   parameter int unsigned NREQ = 2,
   parameter int unsigned NOUT = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NREQ-1:0]      req_n,
   input logic [NREQ*NOUT-1:0] grp_map,
   input logic                 drive_mode,
   input logic [NOUT-1:0]      dif_t,
   input logic [NOUT-1:0]      dif_c,
   input logic [NOUT-1:0]      oe_t,
   input logic [NOUT-1:0]      oe_c,
   input logic [NREQ-1:0]      req_act,
   input logic [NOUT-1:0]      stop_q
);

   logic [NOUT-1:0] cw;

   always_comb begin
      cw = '0;
      for (int j = 0; j < NOUT; j++) begin
         for (int r = 0; r < NREQ; r++) begin
            cw[j] = cw[j] | (req_act[r] & grp_map[r*NOUT + j]);
         end
      end
   end

   AST_DRIVEN_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(drive_mode) |-> (&oe_t) && (dif_c == ~dif_t)); // R5

   genvar r;
   generate
      for (r = 0; r < NREQ; r++) begin : g_req
         AST_DEB_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_act[r]) |-> !$past(req_n[r], 2) && !$past(req_n[r], 3)); // R2
         AST_DEB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req_act[r]) |-> $past(req_n[r], 2) && $past(req_n[r], 3)); // R2
      end
   endgenerate

   genvar j;
   generate
      for (j = 0; j < NOUT; j++) begin : g_pair
         AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stop_q[j]) |-> $past(cw[j])); // R3
         AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stop_q[j]) |-> $past(dif_t[j]) == drive_mode); // R4
         AST_RESUME_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stop_q[j]) |-> !$past(cw[j]) && !$past(cw[j], 2)); // R7
         AST_LEGS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
            oe_t[j] == oe_c[j]); // R6
         AST_FLOAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_t[j] |-> !dif_t[j] && !dif_c[j] && $past(drive_mode)); // R6
      end
   endgenerate

endmodule

bind dif_req_gate dif_req_gate_chk #(
   .NREQ (NREQ),
   .NOUT (NOUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_n      (req_n),
   .grp_map    (grp_map),
   .drive_mode (drive_mode),
   .dif_t      (dif_t),
   .dif_c      (dif_c),
   .oe_t       (oe_t),
   .oe_c       (oe_c),
   .req_act    (req_act),
   .stop_q     (stop_q)
);

// File: tb/tb_dif_req_gate.sv
module tb_dif_req_gate;

   localparam int NREQ = 2;
   localparam int NOUT = 8;
   localparam int LAT  = 2;

   typedef struct {
      int              cyc;
      logic [NOUT-1:0] mask;
      string           tag;
   } exp_t;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NREQ-1:0]      req_n = '1;
   logic [NREQ*NOUT-1:0] grp_map = {8'hF0, 8'h4F};
   logic                 drive_mode = 1'b0;
   logic [NOUT-1:0]      dif_t, dif_c, oe_t, oe_c;

   int              cyc = 0;
   int              total = 0;
   int              bad = 0;
   bit              done = 0;
   logic [NOUT-1:0] cur_mask = '0;
   exp_t            q[$];

   always #5 clk = ~clk;

   dif_req_gate #(
      .NREQ (NREQ),
      .NOUT (NOUT),
      .RESUME_LAT (LAT)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_n      (req_n),
      .grp_map    (grp_map),
      .drive_mode (drive_mode),
      .dif_t      (dif_t),
      .dif_c      (dif_c),
      .oe_t       (oe_t),
      .oe_c       (oe_c)
   );

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic compare(input logic [NOUT-1:0] mask, input string tag);
      logic [NOUT-1:0] et, ec, eo;
      for (int j = 0; j < NOUT; j++) begin
         if (mask[j]) begin
            et[j] = drive_mode ? 1'b0 : 1'b1;
            ec[j] = 1'b0;
            eo[j] = drive_mode ? 1'b0 : 1'b1;
         end else begin
            et[j] = (cyc % 2 == 1);
            ec[j] = ~et[j];
            eo[j] = 1'b1;
         end
      end
      total++;
      if (dif_t !== et || dif_c !== ec || oe_t !== eo || oe_c !== eo) begin
         bad++;
         $display("FAIL %s cyc=%0d t=%h c=%h oe=%h/%h expected t=%h c=%h oe=%h",
                  tag, cyc, dif_t, dif_c, oe_t, oe_c, et, ec, eo);
      end
   endtask

   // Monitor: pop expectations as their cycle arrives
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t it;
            it = q.pop_front();
            if (it.cyc != cyc) begin
               total++;
               bad++;
               $display("FAIL %s missed cyc actual=%0d expected=%0d", it.tag, cyc, it.cyc);
            end else begin
               compare(it.mask, it.tag);
            end
         end
      end
   end

   task automatic push(input int c, input logic [NOUT-1:0] m, input string tag);
      exp_t it;
      it.cyc = c; it.mask = m; it.tag = tag;
      q.push_back(it);
   endtask

   // Driver: change requests and predict the stop or resume edge
   task automatic step(input logic [NREQ-1:0] nreq, input bit is_assert,
                       input logic [NOUT-1:0] nmask, input string tag);
      int c0, e;
      @(negedge clk);
      c0 = cyc;
      req_n = nreq;
      if (is_assert) begin
         e = c0 + 5;
         while ((e % 2 == 1) != (drive_mode == 1'b0)) e++;
      end else begin
         e = c0 + 4 + LAT;
      end
      push(e - 1, cur_mask, tag);
      push(e, nmask, tag);
      push(e + 1, nmask, tag);
      cur_mask = nmask;
      repeat (10) @(negedge clk);
   endtask

   task automatic glitch(input int idx);
      int c0;
      @(negedge clk);
      c0 = cyc;
      req_n[idx] = 1'b0;
      @(negedge clk);
      req_n[idx] = 1'b1;
      for (int k = 3; k <= 8; k++) push(c0 + k, cur_mask, "R2 glitch");
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      total++;
      if (dif_t !== '0 || dif_c !== '1 || oe_t !== '1 || oe_c !== '1) begin
         bad++;
         $display("FAIL R1 reset t=%h c=%h oe=%h/%h expected t=00 c=ff oe=ff/ff",
                  dif_t, dif_c, oe_t, oe_c);
      end
      rst_n = 1'b1;
      for (int k = 1; k <= 4; k++) push(k, '0, "R1 toggle");
      repeat (6) @(negedge clk);

      glitch(0);
      glitch(1);
      // mode 0, one group, unmapped pairs keep running
      step(2'b10, 1, 8'h4F, "R3 R4 R5 stop req0");
      step(2'b11, 0, 8'h00, "R7 resume req0");
      // overlap of groups on pair 6
      step(2'b10, 1, 8'h4F, "R9 stop req0");
      step(2'b00, 1, 8'hFF, "R9 stop req1 added");
      step(2'b01, 0, 8'hF0, "R9 R7 partial release");
      step(2'b11, 0, 8'h00, "R9 R8 final release");
      // mode 1, released legs
      @(negedge clk);
      drive_mode = 1'b1;
      repeat (3) @(negedge clk);
      step(2'b01, 1, 8'hF0, "R4 R6 stop req1 float");
      step(2'b11, 0, 8'h00, "R7 resume float");
      step(2'b00, 1, 8'hFF, "R6 stop both");
      step(2'b11, 0, 8'h00, "R8 same-edge release");
      glitch(1);

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL queue left=%0d expected=0", q.size());
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule